// File: doc/BRIEF.md
# Conversion Result Compare Filter

This block sits between a converter's result path and its result register. It decides whether each result that arrives meets a programmable acceptance condition. The condition can be a single threshold (at or above, or strictly below, limit A) or a window built from limit A and limit B. In a window test the result must fall inside the window or outside it, and the window edges either count as a match or do not. When a result is accepted, the block raises a one-cycle done pulse and copies the result into its held-result register. A rejected result leaves both untouched.

One select bit, `cmp_ge`, sets two things at once. In threshold mode it picks the direction of the test. In window mode it picks whether the edges are included. The order of the two limits decides between an inside test and an outside test. Operands are compared as two's complement when `res_signed` is high (differential conversions) and as unsigned otherwise (single-ended conversions).

Top module: `adc_cmp_filter`

## Requirements
- R1: With `cmp_enable` low, every valid result passes, whatever the limits and the mode bits are.
- R2: Threshold mode (`cmp_window`=0) with `cmp_ge`=1: a result passes when result >= A.
- R3: Threshold mode with `cmp_ge`=0: a result passes when result < A.
- R4: Window mode with A <= B and `cmp_ge`=1: a result passes when A <= result <= B.
- R5: Window mode with A > B and `cmp_ge`=1: a result passes when result <= B or result >= A.
- R6: Window mode with A <= B and `cmp_ge`=0: a result passes when A < result < B.
- R7: Window mode with A > B and `cmp_ge`=0: a result passes when result < B or result > A.
- R8: With `res_signed`=1, the result and both limits are read as two's complement for every comparison, including the A/B order. With `res_signed`=0 they are read as unsigned.
- R9: `out_valid` is high in exactly the cycle after a cycle with `res_valid` high. `out_pass` carries the verdict in that cycle and is 0 whenever `out_valid` is 0.
- R10: `done_pulse` is high only with `out_valid` and `out_pass` both high. `held_result` takes the result only on such a pass and otherwise keeps its value.
- R11: After reset, `out_valid`, `out_pass` and `done_pulse` are 0 and `held_result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | Result strobe |
| res_data | input | W | Incoming conversion result |
| res_signed | input | 1 | 1: two's complement operands, 0: unsigned |
| cmp_enable | input | 1 | Compare filter enable |
| cmp_ge | input | 1 | Threshold direction / window inclusiveness |
| cmp_window | input | 1 | 1: window test, 0: threshold test |
| cmp_lim_a | input | W | Limit A |
| cmp_lim_b | input | W | Limit B |
| out_valid | output | 1 | Verdict strobe |
| out_pass | output | 1 | Verdict: 1 = accepted |
| done_pulse | output | 1 | Completion pulse on an accepted result |
| held_result | output | W | Last accepted result |

## Verification
Directed patterns put the result exactly on limit A, exactly on limit B, and one step to each side of them, in all six modes. These patterns separate the inclusive tests from the exclusive ones and the threshold direction from its inverse. Further runs place negative results and limits in signed mode, to expose any unsigned ordering, and swap the limit order so that inside and outside tests are told apart. A long random run with gaps in the strobe then checks the verdicts, the one-cycle timing, and that `held_result` holds its value across rejected results and idle cycles.

// File: rtl/adc_cmp_pkg.sv
package adc_cmp_pkg;

  // Ordering flags of a result against both limits
  typedef struct packed {
    logic r_lt_a;
    logic r_eq_a;
    logic r_lt_b;
    logic r_eq_b;
    logic a_gt_b;
  } cmp_flags_t;

  typedef enum logic [1:0] {
    TEST_OFF   = 2'd0,
    TEST_THR   = 2'd1,
    TEST_INSIDE  = 2'd2,
    TEST_OUTSIDE = 2'd3
  } cmp_test_t;

  function automatic cmp_test_t pick_test(logic en, logic window, logic a_gt_b);
    if (!en)         return TEST_OFF;
    else if (!window) return TEST_THR;
    else if (a_gt_b) return TEST_OUTSIDE;
    else             return TEST_INSIDE;
  endfunction

  // Verdict from flags; incl doubles as threshold direction
  function automatic logic verdict(cmp_test_t t, cmp_flags_t f, logic incl);
    logic ge_a, gt_a, le_b, lt_b;
    ge_a = !f.r_lt_a;
    gt_a = !f.r_lt_a && !f.r_eq_a;
    le_b = f.r_lt_b || f.r_eq_b;
    lt_b = f.r_lt_b;
    case (t)
      TEST_OFF:     return 1'b1;
      TEST_THR:     return incl ? ge_a : f.r_lt_a;
      TEST_INSIDE:  return incl ? (ge_a && le_b) : (gt_a && lt_b);
      default:      return incl ? (le_b || ge_a) : (lt_b || gt_a);
    endcase
  endfunction

endpackage

// File: rtl/adc_cmp_mag.sv
module adc_cmp_mag #(
  parameter int W = 12
) (
  input  logic                      sgn,
  input  logic [W-1:0]              r,
  input  logic [W-1:0]              a,
  input  logic [W-1:0]              b,
  output adc_cmp_pkg::cmp_flags_t   flags
);
  localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

  // Flipping the top bit maps two's complement order onto unsigned order
  function automatic logic [W-1:0] order_key(logic [W-1:0] x, logic s);
    return s ? (x ^ TOP_BIT) : x;
  endfunction

  logic [W-1:0] kr, ka, kb;
  assign kr = order_key(r, sgn);
  assign ka = order_key(a, sgn);
  assign kb = order_key(b, sgn);

  always_comb begin
    flags.r_lt_a = kr < ka;
    flags.r_eq_a = kr == ka;
    flags.r_lt_b = kr < kb;
    flags.r_eq_b = kr == kb;
    flags.a_gt_b = ka > kb;
  end
endmodule

// File: rtl/adc_cmp_judge.sv
module adc_cmp_judge (
  input  logic                    en,
  input  logic                    ge,
  input  logic                    window,
  input  adc_cmp_pkg::cmp_flags_t flags,
  output adc_cmp_pkg::cmp_test_t  test_kind,
  output logic                    pass
);
  import adc_cmp_pkg::*;

  assign test_kind = pick_test(en, window, flags.a_gt_b);
  assign pass      = verdict(test_kind, flags, ge);
endmodule

// File: rtl/adc_cmp_filter.sv
module adc_cmp_filter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         res_valid,
  input  logic [W-1:0] res_data,
  input  logic         res_signed,
  input  logic         cmp_enable,
  input  logic         cmp_ge,
  input  logic         cmp_window,
  input  logic [W-1:0] cmp_lim_a,
  input  logic [W-1:0] cmp_lim_b,
  output logic         out_valid,
  output logic         out_pass,
  output logic         done_pulse,
  output logic [W-1:0] held_result
);
  import adc_cmp_pkg::*;

  cmp_flags_t flags;
  cmp_test_t  test_kind;
  logic       pass_now;
  logic       accept_now;

  adc_cmp_mag #(.W(W)) u_mag (
    .sgn   (res_signed),
    .r     (res_data),
    .a     (cmp_lim_a),
    .b     (cmp_lim_b),
    .flags (flags)
  );

  adc_cmp_judge u_judge (
    .en        (cmp_enable),
    .ge        (cmp_ge),
    .window    (cmp_window),
    .flags     (flags),
    .test_kind (test_kind),
    .pass      (pass_now)
  );

  // Named event: this strobe's result is committed
  assign accept_now = res_valid && pass_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_pass    <= 1'b0;
      done_pulse  <= 1'b0;
      held_result <= '0;
    end else begin
      out_valid  <= res_valid;
      out_pass   <= accept_now;
      done_pulse <= accept_now;
      if (accept_now) held_result <= res_data;
    end
  end

  // R9: verdict strobe one cycle after the result strobe
  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> out_valid);
  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |=> (!out_valid && !out_pass));
  // R1: bypass when disabled
  assert_bypass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !cmp_enable) |=> out_pass);
  // R10: completion only on an accepted verdict
  assert_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (out_valid && out_pass));
  assert_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done_pulse |-> $stable(held_result));
  // R2: threshold at-or-above accepts a result equal to limit A
  assert_thr_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && cmp_enable && !cmp_window && cmp_ge && res_data == cmp_lim_a) |=> out_pass);
  // R6 and R7: exclusive window tests reject a result equal to limit A
  assert_excl_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && cmp_enable && cmp_window && !cmp_ge && res_data == cmp_lim_a) |=> !out_pass);
endmodule

// File: tb/adc_cmp_filter_bench.sv
`timescale 1ns/1ps
module adc_cmp_filter_bench;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         res_valid = 1'b0;
  logic [W-1:0] res_data = '0;
  logic         res_signed = 1'b0;
  logic         cmp_enable = 1'b0;
  logic         cmp_ge = 1'b0;
  logic         cmp_window = 1'b0;
  logic [W-1:0] cmp_lim_a = '0;
  logic [W-1:0] cmp_lim_b = '0;
  logic         out_valid, out_pass, done_pulse;
  logic [W-1:0] held_result;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // Reference state
  bit           m_valid = 0;
  bit           m_pass = 0;
  logic [W-1:0] m_held = '0;
  string        m_tag = "R11";

  always #4 clk = ~clk;

  adc_cmp_filter #(.W(W)) u_adc_cmp_filter (
    .clk, .rst_n, .res_valid, .res_data, .res_signed, .cmp_enable, .cmp_ge,
    .cmp_window, .cmp_lim_a, .cmp_lim_b, .out_valid, .out_pass, .done_pulse,
    .held_result
  );

  function automatic int as_num(logic [W-1:0] x, bit sg);
    int v = int'(x);
    if (sg && x[W-1]) v = v - (1 << W);
    return v;
  endfunction

  function automatic bit ref_pass(int r, int a, int b, bit en, bit ge, bit win);
    if (!en) return 1;
    if (!win) return ge ? (r >= a) : (r < a);
    if (a <= b) return ge ? (r >= a && r <= b) : (r > a && r < b);
    return ge ? (r <= b || r >= a) : (r < b || r > a);
  endfunction

  function automatic string ref_tag(int a, int b, bit en, bit ge, bit win, bit sg);
    if (sg && en) return "R8";
    if (!en) return "R1";
    if (!win) return ge ? "R2" : "R3";
    if (a <= b) return ge ? "R4" : "R6";
    return ge ? "R5" : "R7";
  endfunction

  task automatic check_bit(string what, string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check_bit("out_valid", "R9", out_valid, m_valid);
    check_bit("out_pass", m_valid ? m_tag : "R9", out_pass, m_valid && m_pass);
    check_bit("done_pulse", "R10", done_pulse, m_valid && m_pass);
    checks++;
    if (held_result !== m_held) begin
      errors++;
      $display("FAIL R10 held_result: got %0h expected %0h", held_result, m_held);
    end
  endtask

  // Drive at a falling edge, compare at the next falling edge
  task automatic step(bit v, logic [W-1:0] r, logic [W-1:0] a, logic [W-1:0] b,
                      bit sg, bit en, bit ge, bit win);
    int ri, ai, bi;
    res_valid = v; res_data = r; cmp_lim_a = a; cmp_lim_b = b;
    res_signed = sg; cmp_enable = en; cmp_ge = ge; cmp_window = win;
    ri = as_num(r, sg); ai = as_num(a, sg); bi = as_num(b, sg);
    m_valid = v;
    m_pass  = ref_pass(ri, ai, bi, en, ge, win);
    m_tag   = ref_tag(ai, bi, en, ge, win, sg);
    if (v && m_pass) m_held = r;
    @(negedge clk);
    compare_all();
  endtask

  // Probe around both limits for one mode
  task automatic sweep(logic [W-1:0] a, logic [W-1:0] b, bit sg, bit en, bit ge, bit win);
    step(1, a, a, b, sg, en, ge, win);
    step(1, a + 1'b1, a, b, sg, en, ge, win);
    step(1, a - 1'b1, a, b, sg, en, ge, win);
    step(1, b, a, b, sg, en, ge, win);
    step(1, b + 1'b1, a, b, sg, en, ge, win);
    step(1, b - 1'b1, a, b, sg, en, ge, win);
    step(0, b, a, b, sg, en, ge, win);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check_bit("out_valid at reset", "R11", out_valid, 1'b0);
    check_bit("done_pulse at reset", "R11", done_pulse, 1'b0);
    checks++;
    if (held_result !== '0) begin
      errors++;
      $display("FAIL R11 held_result: got %0h expected 0", held_result);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1 bypass, R2/R3 thresholds, R4-R7 windows, unsigned
    for (int ge = 0; ge < 2; ge++) begin
      sweep(12'd100, 12'd50, 0, 0, ge[0], 1);
      sweep(12'd100, 12'd200, 0, 1, ge[0], 0);
      sweep(12'd100, 12'd200, 0, 1, ge[0], 1);
      sweep(12'd300, 12'd200, 0, 1, ge[0], 1);
      sweep(12'd7, 12'd7, 0, 1, ge[0], 1);
    end
    // R8: negative limits and results in signed mode
    for (int ge = 0; ge < 2; ge++) begin
      sweep(12'hF00, 12'd20, 1, 1, ge[0], 1);
      sweep(12'd20, 12'hF00, 1, 1, ge[0], 1);
      sweep(12'hFF0, 12'd5, 1, 1, ge[0], 0);
      sweep(12'h7FF, 12'h800, 1, 1, ge[0], 1);
    end
    // Random mix with gaps in the strobe
    for (int i = 0; i < 4000; i++) begin
      logic [W-1:0] a, b, r;
      a = W'($urandom);
      b = ($urandom % 3 == 0) ? a + W'($urandom % 4) : W'($urandom);
      case ($urandom % 4)
        0: r = a;
        1: r = b;
        2: r = a + W'($urandom % 5) - W'(2);
        default: r = W'($urandom);
      endcase
      step(($urandom % 4) != 0, r, a, b, $urandom % 2, ($urandom % 6) != 0,
           $urandom % 2, $urandom % 2);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule